// File: doc/BRIEF.md
# MSI Doorbell to Interrupt Line Decoder

The block receives message-signalled interrupts through a small memory-mapped doorbell. A bus write into its 8-byte window carries a vector number in the lowest data byte. The block subtracts a fixed vector base from that number. The result selects one of `NUM_LINES` interrupt output lines, and the block latches a request on that line. The latched request holds until the consumer acknowledges it on a per-line clear input.

A second set of wired, level-sensitive interrupt inputs shares the same outputs. Each output line is the OR of its latched doorbell bit and the wired input of the same index. A doorbell write whose vector falls outside the configured range is dropped. Such a write sets a sticky error flag, which only reset clears. Reads from the window always return zero.

The error flag is tracked by a two-state machine. State `ERR_CLEAN` moves to state `ERR_STICKY` on the transition `BAD_VECTOR`, which is taken whenever a write is rejected. `ERR_STICKY` holds, through the transition `HOLD`, until reset returns the machine to `ERR_CLEAN`. The elaboration is rejected if `NUM_LINES` is outside 1..`MAX_LINES` or if `VEC_BASE` is outside 0..255.

Top module: `msi_doorbell_decoder`

## Requirements
- R1: A write with `wr_en` high uses only `wr_data[7:0]` (byte lane 0, little-endian) as the vector. Upper data bits and the 3-bit byte offset `wr_addr` have no effect on the result.
- R2: For a vector v with 0 <= v - `VEC_BASE` < `NUM_LINES`, the write sets output line v - `VEC_BASE`. The line is high from the clock edge that accepts the write onward.
- R3: A set line stays high while its ack is low, through idle cycles and through writes to other lines. A doorbell write never clears any line.
- R4: A pulse on `ack[i]` without a simultaneous doorbell to line i clears latched line i at that edge. Afterwards `irq_out[i]` follows `wired_in[i]` only.
- R5: If `ack[i]` is high in the same cycle as a valid doorbell write to line i, line i stays set.
- R6: `irq_out` is the bitwise OR of the latched doorbell bits and `wired_in`, combinationally within the same cycle.
- R7: A vector below `VEC_BASE`, or one whose index is not below `NUM_LINES`, changes no output line. It sets `err_flag` from the next edge onward, and the flag stays high until reset.
- R8: `rd_data` is zero at every byte offset, before and after any writes.
- R9: A synchronous active-high `rst` clears all latched bits and `err_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Doorbell write strobe, accepted every cycle |
| wr_addr | input | 3 | Byte offset inside the 8-byte window |
| wr_data | input | DATA_W | Write data; byte 0 carries the vector |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Read byte offset |
| rd_data | output | DATA_W | Read data, registered, always zero |
| wired_in | input | NUM_LINES | Wired level interrupt inputs |
| ack | input | NUM_LINES | Per-line clear of the latched doorbell bit |
| irq_out | output | NUM_LINES | Interrupt output lines |
| err_flag | output | 1 | Sticky out-of-range vector flag |

## Verification
The bench builds the block with `NUM_LINES` = 8 and `VEC_BASE` = 40. With these values, all 256 vector values can be swept, each from a fresh reset. The sweep covers both rejection sides: negative indices 0..39 and indices past the top from 48 upward. It also covers the exact boundaries 39, 40, 47 and 48, with random upper data bits and every byte offset.

Eight lines also keep the wired inputs small enough to try every one of the 256 patterns. These patterns are applied both with and without a latched bit underneath. The bench also exercises acknowledge and doorbell collisions on the same line and on different lines.

// File: rtl/msidb_pkg.sv
`timescale 1ns/1ps
package msidb_pkg;

    localparam int VEC_W   = 8;
    localparam int WIN_AW  = 3;

    typedef enum logic {
        ERR_CLEAN  = 1'b0,
        ERR_STICKY = 1'b1
    } err_state_e;

endpackage

// File: rtl/msidb_decode.sv
`timescale 1ns/1ps
module msidb_decode #(
    parameter int NUM_LINES = 32,
    parameter int VEC_BASE  = 64
) (
    input  logic                      wr_en,
    input  logic [msidb_pkg::VEC_W-1:0] vec,
    output logic [NUM_LINES-1:0]      set_vec,
    output logic                      bad_wr
);
    localparam int DW = msidb_pkg::VEC_W + 1;

    logic [DW-1:0] offset;
    logic          below_base;
    logic          in_range;

    always_comb begin
        below_base = ({1'b0, vec} < DW'(VEC_BASE));
        offset     = {1'b0, vec} - DW'(VEC_BASE);
        in_range   = !below_base && (32'(offset) < NUM_LINES);
        bad_wr     = wr_en && !in_range;
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_sel
        assign set_vec[i] = wr_en && in_range && (offset == DW'(i));
    end

endmodule

// File: rtl/msidb_lines.sv
`timescale 1ns/1ps
module msidb_lines #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] set_vec,
    input  logic [NUM_LINES-1:0] ack,
    input  logic [NUM_LINES-1:0] wired_in,
    output logic [NUM_LINES-1:0] irq_out
);
    logic [NUM_LINES-1:0] held;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                held[i] <= 1'b0;
            end else if (set_vec[i]) begin
                held[i] <= 1'b1;
            end else if (ack[i]) begin
                held[i] <= 1'b0;
            end
        end
        assign irq_out[i] = held[i] | wired_in[i];
    end

endmodule

// File: rtl/msidb_errfsm.sv
`timescale 1ns/1ps
module msidb_errfsm (
    input  logic clk,
    input  logic rst,
    input  logic bad_wr,
    output logic err_flag
);
    import msidb_pkg::*;

    err_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ERR_CLEAN;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ERR_CLEAN:  if (bad_wr) state_d = ERR_STICKY;
            ERR_STICKY: state_d = ERR_STICKY;
            default:    state_d = ERR_CLEAN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ERR_CLEAN:  err_flag = 1'b0;
            ERR_STICKY: err_flag = 1'b1;
            default:    err_flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/msi_doorbell_decoder.sv
`timescale 1ns/1ps
module msi_doorbell_decoder #(
    parameter int NUM_LINES = 32,
    parameter int MAX_LINES = 256,
    parameter int VEC_BASE  = 64,
    parameter int DATA_W    = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [2:0]           wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_en,
    input  logic [2:0]           rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    input  logic [NUM_LINES-1:0] wired_in,
    input  logic [NUM_LINES-1:0] ack,
    output logic [NUM_LINES-1:0] irq_out,
    output logic                 err_flag
);
    localparam int VW = msidb_pkg::VEC_W;

    if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_lines
        $error("msi_doorbell_decoder: NUM_LINES out of 1..MAX_LINES");
    end
    if (VEC_BASE < 0 || VEC_BASE > 255) begin : g_bad_base
        $error("msi_doorbell_decoder: VEC_BASE out of 0..255");
    end

    logic [NUM_LINES-1:0] set_vec;
    logic                 bad_wr;
    logic                 unused_bits;

    assign unused_bits = ^{wr_data[DATA_W-1:VW], wr_addr, rd_addr};

    msidb_decode #(
        .NUM_LINES (NUM_LINES),
        .VEC_BASE  (VEC_BASE)
    ) u_decode (
        .wr_en   (wr_en),
        .vec     (wr_data[VW-1:0]),
        .set_vec (set_vec),
        .bad_wr  (bad_wr)
    );

    msidb_lines #(
        .NUM_LINES (NUM_LINES)
    ) u_lines (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .ack      (ack),
        .wired_in (wired_in),
        .irq_out  (irq_out)
    );

    msidb_errfsm u_err (
        .clk      (clk),
        .rst      (rst),
        .bad_wr   (bad_wr),
        .err_flag (err_flag)
    );

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= '0;
    end

endmodule

// File: rtl/msidb_chk.sv
`timescale 1ns/1ps
module msidb_chk #(
    parameter int NUM_LINES = 32,
    parameter int VEC_BASE  = 64,
    parameter int DATA_W    = 64
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [DATA_W-1:0]    wr_data,
    input logic [NUM_LINES-1:0] wired_in,
    input logic [NUM_LINES-1:0] ack,
    input logic [NUM_LINES-1:0] irq_out,
    input logic                 err_flag
);
    int  c_idx;
    logic c_good;
    logic c_bad;

    always_comb begin
        c_idx  = int'(wr_data[7:0]) - VEC_BASE;
        c_good = wr_en && (c_idx >= 0) && (c_idx < NUM_LINES);
        c_bad  = wr_en && !((c_idx >= 0) && (c_idx < NUM_LINES));
    end

    // R2
    doorbell_sets_line_chk: assert property (@(posedge clk) disable iff (rst)
        c_good |=> irq_out[$past(c_idx)]);

    // R7
    bad_vector_flags_chk: assert property (@(posedge clk) disable iff (rst)
        c_bad |=> err_flag);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    // R4
    ack_all_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && (&ack)) |=> ((irq_out & ~wired_in) == '0));

    // R9
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!err_flag && (irq_out == wired_in)));

endmodule

bind msi_doorbell_decoder msidb_chk #(
    .NUM_LINES (NUM_LINES),
    .VEC_BASE  (VEC_BASE),
    .DATA_W    (DATA_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .wired_in (wired_in),
    .ack      (ack),
    .irq_out  (irq_out),
    .err_flag (err_flag)
);

// File: tb/msi_doorbell_decoder_test.sv
`timescale 1ns/1ps
module msi_doorbell_decoder_test;
    localparam int N    = 8;
    localparam int BASE = 40;
    localparam int DW   = 64;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en;
    logic [2:0]    wr_addr;
    logic [DW-1:0] wr_data;
    logic          rd_en;
    logic [2:0]    rd_addr;
    logic [DW-1:0] rd_data;
    logic [N-1:0]  wired_in;
    logic [N-1:0]  ack;
    logic [N-1:0]  irq_out;
    logic          err_flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    msi_doorbell_decoder #(
        .NUM_LINES (N),
        .MAX_LINES (32),
        .VEC_BASE  (BASE),
        .DATA_W    (DW)
    ) uut (
        .clk (clk), .rst (rst),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data),
        .wired_in (wired_in), .ack (ack),
        .irq_out (irq_out), .err_flag (err_flag)
    );

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; ack = '0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // drive one write for one cycle; return at the following negedge
    task automatic doorbell(logic [DW-1:0] data, logic [2:0] off, logic [N-1:0] a);
        wr_en = 1'b1; wr_data = data; wr_addr = off; ack = a;
        @(negedge clk);
        wr_en = 1'b0; ack = '0;
    endtask

    task automatic pulse_ack(logic [N-1:0] a);
        ack = a;
        @(negedge clk);
        ack = '0;
    endtask

    task automatic read_zero(logic [2:0] off, string req);
        rd_en = 1'b1; rd_addr = off;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rd_data, '0);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_en = 1'b0; rd_addr = '0; wired_in = '0; ack = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check("R9 reset irq", 64'(irq_out), 0);
        check("R9 reset err", 64'(err_flag), 0);
        read_zero(3'd0, "R8 read after reset");

        // R1 R2 R7: sweep every vector value from a fresh reset
        for (int v = 0; v < 256; v++) begin
            logic [DW-1:0] d;
            int idx;
            do_reset();
            d = {$urandom(), $urandom()};
            d[7:0] = 8'(v);
            idx = v - BASE;
            doorbell(d, 3'(v), '0);
            if (idx >= 0 && idx < N) begin
                check("R2 line set", 64'(irq_out), 64'(1) << idx);
                check("R1 no error on good vector", 64'(err_flag), 0);
            end else begin
                check("R7 dropped vector", 64'(irq_out), 0);
                check("R7 err flag", 64'(err_flag), 1);
            end
            read_zero(3'(v + 3), "R8 read zero");
        end

        // R1 upper bits / offset ignored: same vector, different uppers
        do_reset();
        doorbell({56'hFFFF_FFFF_FFFF_FF, 8'(BASE + 2)}, 3'd7, '0);
        doorbell({56'h00_0000_0000_0100, 8'(BASE + 5)}, 3'd1, '0);
        check("R1 upper bits ignored", 64'(irq_out), 64'h24);
        check("R1 no err", 64'(err_flag), 0);

        // R3 holds through idle and other writes
        repeat (5) @(negedge clk);
        check("R3 held through idle", 64'(irq_out), 64'h24);
        doorbell(64'(BASE + 2), 3'd0, '0);
        check("R3 rewrite keeps set", 64'(irq_out), 64'h24);

        // R4 ack clears one line
        pulse_ack(8'h04);
        check("R4 ack clears line 2", 64'(irq_out), 64'h20);

        // R5 collision on the same line
        doorbell(64'(BASE + 5), 3'd0, 8'h20);
        check("R5 ack+set same line", 64'(irq_out), 64'h20);
        // ack one line while writing another
        doorbell(64'(BASE + 0), 3'd0, 8'h20);
        check("R4 ack with other write", 64'(irq_out), 64'h01);

        // R6 wired passthrough over all patterns, with bit 0 latched
        for (int w = 0; w < 256; w++) begin
            wired_in = 8'(w);
            #1;
            check("R6 wired OR latched", 64'(irq_out), 64'(w | 1));
            @(negedge clk);
        end
        pulse_ack(8'hFF);
        for (int w = 0; w < 256; w++) begin
            wired_in = 8'(w);
            #1;
            check("R6 wired only", 64'(irq_out), 64'(w));
            @(negedge clk);
        end
        // R4 ack does not mask wired level
        wired_in = 8'h10;
        pulse_ack(8'h10);
        check("R4 wired survives ack", 64'(irq_out), 64'h10);
        wired_in = '0;

        // R7 sticky across good writes, R9 reset clears everything
        doorbell(64'(BASE + N), 3'd0, '0);
        doorbell(64'(BASE + 3), 3'd0, '0);
        check("R7 sticky err", 64'(err_flag), 1);
        check("R7 good write still works", 64'(irq_out), 64'h08);
        do_reset();
        check("R9 reset clears lines", 64'(irq_out), 0);
        check("R9 reset clears err", 64'(err_flag), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule